// File: doc/BRIEF.md
# Queue-to-vector interrupt cause chainer

This block turns per-queue receive and transmit completion events into interrupt requests on a set of vectors. Software builds one singly linked list of queue entries per vector. The head register of a list names the first entry. Each queue's control word names the entry that follows it, together with the vector the entry belongs to, a throttle class, a cause-enable bit and a shared-mode cause bit select. One walker per vector follows its list at one entry per clock, forever. When the walker finds an enabled entry whose queue has a latched event, it raises that vector's request. The request and the claimed events stay set until the vector is acknowledged.

Vector 0 carries the non-queue causes, which arrive on a single input. In the normal vectored mode, head register h roots the list of vector h+1. In shared mode every per-vector walker is idle. A separate head register then roots a single list for vector 0, and each hit also sets one bit of a small cause register that software reads and that clears on acknowledge. A bound on list length catches lists that loop back on themselves.

Top module: `icc_chainer`

## Requirements
- R1: After reset, every head register and the shared head read 0x7FF, every control word reads 0x7FF, the mode and cause registers read 0, and `vec_req` and `loop_err` are all low.
- R2: The register address is split as region = addr[7:6] and index = addr[5:0]. Region 0 holds mode (index 0, bit 0 = shared mode), shared head (index 1) and cause (index 2, read only). Region 1 is head register h. Region 2 is the receive control word of pair q, and region 3 is the transmit control word of pair q. A head word holds the first index in bits [10:0] and the type in bit 11 (0 receive, 1 transmit). A control word holds next index [10:0], next type [11], throttle class [13:12], cause enable [14], cause select [17:15] and vector [25:18]. Every written field reads back unchanged, and the throttle class has no effect on requests.
- R3: In vectored mode, an event on a queue whose entry is reachable from head h, with cause enable set and vector field h+1, raises `vec_req[h+1]` within one full walk of that list. The request then stays high until `vec_ack[h+1]`.
- R4: An index of 0x7FF, or any index not below NUM_PAIRS, ends a list. A head holding such a value gives an empty list, and events on that vector's queues raise nothing.
- R5: An entry with cause enable clear contributes no request, but the walk still passes through it to the entries after it.
- R6: An entry whose vector field differs from the vector of the list it sits on contributes no request.
- R7: A pulse on `other_evt` sets `vec_req[0]` at the next clock edge, in either mode.
- R8: Acknowledging a vector clears its request at the next edge. It also clears the latched events of the queues that vector has claimed since its last acknowledge. Events not yet claimed, including ones arriving in the acknowledge cycle, stay latched and raise the request again.
- R9: A one-cycle event pulse stays latched per queue, whatever the walker is visiting, until a vector that claimed it is acknowledged.
- R10: A walk that visits 2*NUM_PAIRS entries without reaching an end sets the sticky `loop_err` bit of that vector and restarts from the head. Writing that vector's head register clears the bit.
- R11: In shared mode the vectored lists are not walked. The list rooted at the shared head raises `vec_req[0]`, and each hit with cause select s below 7 sets bit s of the cause register. A select of 7 sets no bit.
- R12: The cause register clears on `vec_ack[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | ADDR_W | Write address |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | ADDR_W | Read address |
| cfg_rdata | output | 32 | Read data, combinational from `cfg_raddr` |
| rx_evt | input | NUM_PAIRS | Receive event pulse per queue pair |
| tx_evt | input | NUM_PAIRS | Transmit event pulse per queue pair |
| other_evt | input | 1 | Non-queue cause pulse for vector 0 |
| vec_ack | input | NUM_VEC | Per-vector acknowledge pulse |
| vec_req | output | NUM_VEC | Per-vector interrupt request |
| loop_err | output | NUM_VEC | Sticky list-loop flag per vector |

## Verification
A walker pointer or counter that goes wrong shows at the ports as a missing request, or a request on the wrong vector, once a full walk has passed. That is at most 2*NUM_PAIRS+1 cycles after the event. A list that never reaches its end shows as a `loop_err` bit within the same bound. A latched event that is wrongly kept or wrongly dropped shows within one walk after the acknowledge: the request either comes back when no new event arrived, or stays low after an event that arrived during the acknowledge cycle. In shared mode, the cause register read back right after a hit exposes a wrong select decode at once.

// File: rtl/icc_pkg.sv
package icc_pkg;
   localparam int          IDX_W    = 11;
   localparam logic [10:0] IDX_END  = 11'h7FF;
   localparam logic [2:0]  SEL_NONE = 3'd7;
   localparam int          CAUSE_W  = 7;

   typedef enum logic [1:0] {
      THR_RX    = 2'd0,
      THR_TX    = 2'd1,
      THR_OTHER = 2'd2,
      THR_NONE  = 2'd3
   } thr_class_e;

   typedef struct packed {
      logic [7:0]       vec;
      logic [2:0]       sel;
      logic             cause_en;
      thr_class_e       thr;
      logic             next_tx;
      logic [IDX_W-1:0] next_idx;
   } ctl_t;

   typedef struct packed {
      logic             first_tx;
      logic [IDX_W-1:0] first_idx;
   } head_t;

   localparam ctl_t  CTL_RST  = '{vec: 8'd0, sel: 3'd0, cause_en: 1'b0,
                                  thr: THR_RX, next_tx: 1'b0, next_idx: IDX_END};
   localparam head_t HEAD_RST = '{first_tx: 1'b0, first_idx: IDX_END};
endpackage

// File: rtl/icc_regfile.sv
module icc_regfile
   import icc_pkg::*;
#(
   parameter int NUM_PAIRS = 8,
   parameter int NUM_VEC   = 4,
   parameter int ADDR_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [ADDR_W-1:0]           waddr,
   input  logic [31:0]                 wdata,
   input  logic [ADDR_W-1:0]           raddr,
   output logic [31:0]                 rdata,
   input  logic [CAUSE_W-1:0]          cause,
   output logic                        shared_mode,
   output head_t [NUM_VEC-1:0]         heads,
   output ctl_t  [NUM_PAIRS-1:0]       rx_ctl,
   output ctl_t  [NUM_PAIRS-1:0]       tx_ctl,
   output logic  [NUM_VEC-1:0]         head_wr
);
   localparam int OFF_W = ADDR_W - 2;
   localparam logic [1:0] REG_MISC = 2'd0;
   localparam logic [1:0] REG_HEAD = 2'd1;
   localparam logic [1:0] REG_RXQ  = 2'd2;
   localparam logic [1:0] REG_TXQ  = 2'd3;

   logic [1:0]       w_reg, r_reg;
   logic [OFF_W-1:0] w_off, r_off;

   assign w_reg = waddr[ADDR_W-1 -: 2];
   assign w_off = waddr[OFF_W-1:0];
   assign r_reg = raddr[ADDR_W-1 -: 2];
   assign r_off = raddr[OFF_W-1:0];

   // head write strobes: slot 0 is the shared head, slot v serves vector v
   always_comb begin
      head_wr = '0;
      if (we && w_reg == REG_MISC && int'(w_off) == 1) head_wr[0] = 1'b1;
      for (int h = 0; h < NUM_VEC - 1; h++)
         if (we && w_reg == REG_HEAD && int'(w_off) == h) head_wr[h+1] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shared_mode <= 1'b0;
         heads       <= {NUM_VEC{HEAD_RST}};
         rx_ctl      <= {NUM_PAIRS{CTL_RST}};
         tx_ctl      <= {NUM_PAIRS{CTL_RST}};
      end else if (we) begin
         if (w_reg == REG_MISC && int'(w_off) == 0) shared_mode <= wdata[0];
         for (int v = 0; v < NUM_VEC; v++)
            if (head_wr[v]) heads[v] <= head_t'(wdata[IDX_W:0]);
         for (int q = 0; q < NUM_PAIRS; q++) begin
            if (w_reg == REG_RXQ && int'(w_off) == q) rx_ctl[q] <= ctl_t'(wdata[$bits(ctl_t)-1:0]);
            if (w_reg == REG_TXQ && int'(w_off) == q) tx_ctl[q] <= ctl_t'(wdata[$bits(ctl_t)-1:0]);
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (r_reg)
         REG_MISC: begin
            if (int'(r_off) == 0) rdata = {31'd0, shared_mode};
            if (int'(r_off) == 1) rdata = 32'(heads[0]);
            if (int'(r_off) == 2) rdata = 32'(cause);
         end
         REG_HEAD: begin
            for (int h = 0; h < NUM_VEC - 1; h++)
               if (int'(r_off) == h) rdata = 32'(heads[h+1]);
         end
         REG_RXQ: begin
            for (int q = 0; q < NUM_PAIRS; q++)
               if (int'(r_off) == q) rdata = 32'(rx_ctl[q]);
         end
         default: begin
            for (int q = 0; q < NUM_PAIRS; q++)
               if (int'(r_off) == q) rdata = 32'(tx_ctl[q]);
         end
      endcase
   end
endmodule

// File: rtl/icc_pending.sv
module icc_pending #(
   parameter int NUM_PAIRS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PAIRS-1:0] rx_evt,
   input  logic [NUM_PAIRS-1:0] tx_evt,
   input  logic [NUM_PAIRS-1:0] rx_clr,
   input  logic [NUM_PAIRS-1:0] tx_clr,
   output logic [NUM_PAIRS-1:0] rx_live,
   output logic [NUM_PAIRS-1:0] tx_live
);
   logic [NUM_PAIRS-1:0] rx_q, tx_q;

   // bits being released this cycle are hidden from the walkers so that a
   // claimed event cannot be re-claimed in its own acknowledge cycle
   assign rx_live = rx_q & ~rx_clr;
   assign tx_live = tx_q & ~tx_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_q <= '0;
         tx_q <= '0;
      end else begin
         rx_q <= rx_live | rx_evt;
         tx_q <= tx_live | tx_evt;
      end
   end
endmodule

// File: rtl/icc_walker.sv
module icc_walker
   import icc_pkg::*;
#(
   parameter int NUM_PAIRS = 8,
   parameter int VID       = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  head_t                 head,
   input  logic                  head_wr,
   input  ctl_t [NUM_PAIRS-1:0]  rx_ctl,
   input  ctl_t [NUM_PAIRS-1:0]  tx_ctl,
   input  logic [NUM_PAIRS-1:0]  rx_pend,
   input  logic [NUM_PAIRS-1:0]  tx_pend,
   output logic                  hit,
   output logic [NUM_PAIRS-1:0]  hit_rx,
   output logic [NUM_PAIRS-1:0]  hit_tx,
   output logic [2:0]            hit_sel,
   output logic                  loop_err
);
   localparam int QW    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
   localparam int BOUND = 2 * NUM_PAIRS;
   localparam int CNT_W = $clog2(BOUND + 1);
   localparam logic [IDX_W-1:0] NP_L = IDX_W'(NUM_PAIRS);

   logic [IDX_W-1:0] cur_idx;
   logic             cur_tx;
   logic [CNT_W-1:0] cnt;
   logic [QW-1:0]    qi;
   ctl_t             ent;
   logic             pend_bit, at_end, next_end, bound_hit;

   assign qi       = cur_idx[QW-1:0];
   assign at_end   = (cur_idx >= NP_L);
   assign ent      = cur_tx ? tx_ctl[qi] : rx_ctl[qi];
   assign pend_bit = cur_tx ? tx_pend[qi] : rx_pend[qi];
   assign next_end = (ent.next_idx >= NP_L);
   assign bound_hit = (cnt == CNT_W'(BOUND - 1)) && !next_end;

   assign hit     = en && !at_end && ent.cause_en && (ent.vec == 8'(VID)) && pend_bit;
   assign hit_sel = ent.sel;

   always_comb begin
      hit_rx = '0;
      hit_tx = '0;
      if (hit) begin
         if (cur_tx) hit_tx[qi] = 1'b1;
         else        hit_rx[qi] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cur_idx <= IDX_END;
         cur_tx  <= 1'b0;
         cnt     <= '0;
      end else if (at_end) begin
         cur_idx <= head.first_idx;
         cur_tx  <= head.first_tx;
         cnt     <= '0;
      end else if (bound_hit) begin
         cur_idx <= IDX_END;
         cur_tx  <= 1'b0;
         cnt     <= '0;
      end else begin
         cur_idx <= ent.next_idx;
         cur_tx  <= ent.next_tx;
         cnt     <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || head_wr) loop_err <= 1'b0;
      else if (en && !at_end && bound_hit) loop_err <= 1'b1;
   end
endmodule

// File: rtl/icc_chainer.sv
module icc_chainer
   import icc_pkg::*;
#(
   parameter int NUM_PAIRS = 8,
   parameter int NUM_VEC   = 4,
   parameter int ADDR_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [ADDR_W-1:0]    cfg_waddr,
   input  logic [31:0]          cfg_wdata,
   input  logic [ADDR_W-1:0]    cfg_raddr,
   output logic [31:0]          cfg_rdata,
   input  logic [NUM_PAIRS-1:0] rx_evt,
   input  logic [NUM_PAIRS-1:0] tx_evt,
   input  logic                 other_evt,
   input  logic [NUM_VEC-1:0]   vec_ack,
   output logic [NUM_VEC-1:0]   vec_req,
   output logic [NUM_VEC-1:0]   loop_err
);
   localparam int MAX_SLOTS = 2 ** (ADDR_W - 2);

   if (NUM_PAIRS < 1 || NUM_PAIRS > MAX_SLOTS) begin : g_bad_pairs
      $error("icc_chainer: NUM_PAIRS out of range for ADDR_W");
   end
   if (NUM_VEC < 2 || NUM_VEC > MAX_SLOTS + 1 || NUM_VEC > 256) begin : g_bad_vec
      $error("icc_chainer: NUM_VEC out of range");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("icc_chainer: ADDR_W too small");
   end

   logic                    shared_mode;
   head_t [NUM_VEC-1:0]     heads;
   ctl_t  [NUM_PAIRS-1:0]   rx_ctl, tx_ctl;
   logic  [NUM_VEC-1:0]     head_wr;
   logic  [CAUSE_W-1:0]     cause_q, cause_set;
   logic  [NUM_PAIRS-1:0]   rx_live, tx_live, rx_clr, tx_clr;
   logic  [NUM_VEC-1:0]     w_hit;
   logic  [2:0]             w_sel  [NUM_VEC];
   logic  [NUM_PAIRS-1:0]   clr_rx_v [NUM_VEC];
   logic  [NUM_PAIRS-1:0]   clr_tx_v [NUM_VEC];

   icc_regfile #(.NUM_PAIRS(NUM_PAIRS), .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
      .raddr(cfg_raddr), .rdata(cfg_rdata), .cause(cause_q), .shared_mode(shared_mode),
      .heads(heads), .rx_ctl(rx_ctl), .tx_ctl(tx_ctl), .head_wr(head_wr)
   );

   icc_pending #(.NUM_PAIRS(NUM_PAIRS)) pend_i (
      .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
      .rx_clr(rx_clr), .tx_clr(tx_clr), .rx_live(rx_live), .tx_live(tx_live)
   );

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      logic                 walk_en, req_q;
      logic [NUM_PAIRS-1:0] h_rx, h_tx, claim_rx, claim_tx;
      logic                 src_other;

      // vector 0 walks only in shared mode, all others only in vectored mode
      if (v == 0) begin : g_v0
         assign walk_en   = shared_mode;
         assign src_other = other_evt;
      end else begin : g_vn
         assign walk_en   = !shared_mode;
         assign src_other = 1'b0;
      end

      icc_walker #(.NUM_PAIRS(NUM_PAIRS), .VID(v)) walk_i (
         .clk(clk), .rst_n(rst_n), .en(walk_en), .head(heads[v]), .head_wr(head_wr[v]),
         .rx_ctl(rx_ctl), .tx_ctl(tx_ctl), .rx_pend(rx_live), .tx_pend(tx_live),
         .hit(w_hit[v]), .hit_rx(h_rx), .hit_tx(h_tx), .hit_sel(w_sel[v]),
         .loop_err(loop_err[v])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            req_q    <= 1'b0;
            claim_rx <= '0;
            claim_tx <= '0;
         end else begin
            req_q    <= (req_q && !vec_ack[v]) || w_hit[v] || src_other;
            claim_rx <= (vec_ack[v] ? '0 : claim_rx) | h_rx;
            claim_tx <= (vec_ack[v] ? '0 : claim_tx) | h_tx;
         end
      end

      assign clr_rx_v[v] = vec_ack[v] ? claim_rx : '0;
      assign clr_tx_v[v] = vec_ack[v] ? claim_tx : '0;
      assign vec_req[v]  = req_q;
   end

   always_comb begin
      rx_clr = '0;
      tx_clr = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         rx_clr = rx_clr | clr_rx_v[v];
         tx_clr = tx_clr | clr_tx_v[v];
      end
   end

   always_comb begin
      cause_set = '0;
      if (w_hit[0] && w_sel[0] != SEL_NONE)
         for (int i = 0; i < CAUSE_W; i++)
            if (w_sel[0] == 3'(i)) cause_set[i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (vec_ack[0] ? '0 : cause_q) | cause_set;
   end
endmodule

// File: rtl/icc_chainer_chk.sv
module icc_chainer_chk #(
   parameter int NUM_VEC = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               shared_mode,
   input logic               other_evt,
   input logic [NUM_VEC-1:0] vec_ack,
   input logic [NUM_VEC-1:0] vec_req,
   input logic [NUM_VEC-1:0] loop_err,
   input logic [NUM_VEC-1:0] head_wr,
   input logic [6:0]         cause_q
);
   AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      |(vec_req & ~vec_ack) |=> ((vec_req & $past(vec_req & ~vec_ack)) == $past(vec_req & ~vec_ack))); // R3
   AST_OTHER_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      other_evt |=> vec_req[0]); // R7
   AST_SHARED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      shared_mode |=> ((vec_req[NUM_VEC-1:1] & ~$past(vec_req[NUM_VEC-1:1])) == '0)); // R11
   AST_CAUSE_VECTORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!shared_mode && cause_q == 7'd0) |=> (cause_q == 7'd0)); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      |(loop_err & ~head_wr) |=> ((loop_err & $past(loop_err & ~head_wr)) == $past(loop_err & ~head_wr))); // R10
   AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      |head_wr |=> ((loop_err & $past(head_wr)) == '0)); // R10
   AST_CAUSE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack[0] && !shared_mode) |=> (cause_q == 7'd0)); // R12
endmodule

bind icc_chainer icc_chainer_chk #(.NUM_VEC(NUM_VEC)) chk_i (
   .clk(clk), .rst_n(rst_n), .shared_mode(shared_mode), .other_evt(other_evt),
   .vec_ack(vec_ack), .vec_req(vec_req), .loop_err(loop_err),
   .head_wr(head_wr), .cause_q(cause_q)
);

// File: tb/icc_chainer_tb.sv
module icc_chainer_tb_top;
   localparam int NP = 8;
   localparam int NV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_waddr = '0, cfg_raddr = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic [NP-1:0] rx_evt = '0, tx_evt = '0;
   logic        other_evt = 1'b0;
   logic [NV-1:0] vec_ack = '0, vec_req, loop_err;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [NP-1:0] pm_rx = '0, pm_tx = '0;

   always #2 clk = ~clk;

   icc_chainer #(.NUM_PAIRS(NP), .NUM_VEC(NV), .ADDR_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .rx_evt(rx_evt), .tx_evt(tx_evt),
      .other_evt(other_evt), .vec_ack(vec_ack), .vec_req(vec_req), .loop_err(loop_err)
   );

   function automatic logic [7:0] a_head(int h); return 8'h40 | 8'(h); endfunction
   function automatic logic [7:0] a_rx(int q);   return 8'h80 | 8'(q); endfunction
   function automatic logic [7:0] a_tx(int q);   return 8'hC0 | 8'(q); endfunction
   function automatic logic [31:0] mk_ctl(int vec, int sel, bit en, int thr, bit ntx, int nidx);
      return {6'd0, 8'(vec), 3'(sel), en, 2'(thr), ntx, 11'(nidx)};
   endfunction
   function automatic int vec_of(int q); return (q % (NV - 1)) + 1; endfunction
   function automatic logic [NV-1:0] exp_req(logic [NP-1:0] r, logic [NP-1:0] t);
      logic [NV-1:0] e = '0;
      for (int q = 0; q < NP; q++) if (r[q] || t[q]) e[vec_of(q)] = 1'b1;
      return e;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask
   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask
   task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
      cfg_raddr = a; #1;
      check(cfg_rdata == exp, tag, cfg_rdata, exp);
   endtask
   task automatic pulse(logic [NP-1:0] r, logic [NP-1:0] t);
      @(negedge clk); rx_evt = r; tx_evt = t;
      @(negedge clk); rx_evt = '0; tx_evt = '0;
   endtask
   task automatic ack(logic [NV-1:0] m);
      @(negedge clk); vec_ack = m;
      @(negedge clk); vec_ack = '0;
   endtask
   task automatic idle(int n); repeat (n) @(negedge clk); endtask
   task automatic req_chk(logic [NV-1:0] exp, string tag);
      check(vec_req == exp, tag, 32'(vec_req), 32'(exp));
   endtask
   task automatic prog(logic [NP-1:0] er, logic [NP-1:0] et);
      for (int h = 0; h < NV - 1; h++) wr(a_head(h), 32'(h));
      for (int q = 0; q < NP; q++) begin
         wr(a_rx(q), mk_ctl(vec_of(q), 0, er[q], 0, 1'b1, q));
         wr(a_tx(q), mk_ctl(vec_of(q), 0, et[q], 1, 1'b0, (q + NV - 1 < NP) ? q + NV - 1 : 11'h7FF));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NP-1:0] er, et, vr, vt;
      void'($urandom(32'd4242));
      idle(3); rst_n = 1'b1; idle(1);
      // R1 reset state
      req_chk('0, "R1 req");
      check(loop_err == '0, "R1 loop_err", 32'(loop_err), 0);
      rd_chk(a_head(0), 32'h7FF, "R1 head0");
      rd_chk(8'h01, 32'h7FF, "R1 shared head");
      rd_chk(a_rx(3), 32'h7FF, "R1 rx3");
      rd_chk(a_tx(7), 32'h7FF, "R1 tx7");
      rd_chk(8'h00, 32'h0, "R1 mode");
      rd_chk(8'h02, 32'h0, "R1 cause");

      // R2 field readback, throttle class kept
      wr(a_rx(5), mk_ctl(3, 5, 1'b1, 2, 1'b1, 5));
      rd_chk(a_rx(5), mk_ctl(3, 5, 1'b1, 2, 1'b1, 5), "R2 rx5 fields");
      wr(a_head(1), 32'h805);
      rd_chk(a_head(1), 32'h805, "R2 head1 fields");

      prog('1, '1);
      // R3 R5 R8 R9 random phase against bench model
      for (int it = 0; it < 16; it++) begin
         er = NP'($urandom); et = NP'($urandom);
         vr = NP'($urandom); vt = NP'($urandom);
         prog(er, et);
         pulse(vr, vt);
         pm_rx |= vr; pm_tx |= vt;
         idle(30);
         req_chk(exp_req(pm_rx & er, pm_tx & et), "R3 R5 R9 random request");
         ack('1);
         pm_rx &= ~er; pm_tx &= ~et;
         idle(3);
         req_chk('0, "R8 random ack");
      end
      prog('1, '1);
      idle(30); ack('1); idle(3);
      pm_rx = '0; pm_tx = '0;
      req_chk('0, "R8 drain");

      // R5 disabled entry passed through
      wr(a_rx(1), mk_ctl(2, 0, 1'b0, 0, 1'b1, 1));
      wr(a_tx(1), mk_ctl(2, 0, 1'b0, 1, 1'b0, 4));
      pulse(8'h02, 8'h80);
      idle(30);
      req_chk(4'b0100, "R5 tx7 behind disabled pair1");
      ack('1); idle(30);
      req_chk(4'b0000, "R5 disabled rx1 silent");
      wr(a_rx(1), mk_ctl(2, 0, 1'b1, 0, 1'b1, 1));
      idle(30);
      req_chk(4'b0100, "R9 rx1 kept latched");
      ack('1); idle(3);
      wr(a_tx(1), mk_ctl(2, 0, 1'b1, 1, 1'b0, 4));

      // R7 other cause
      @(negedge clk); other_evt = 1'b1;
      @(negedge clk); other_evt = 1'b0;
      check(vec_req[0] == 1'b1, "R7 other raises vector 0", 32'(vec_req), 1);
      ack(4'b0001); idle(2);
      req_chk('0, "R7 vector 0 acked");

      // R8 event in acknowledge cycle kept
      pulse(8'h01, 8'h00);
      idle(30);
      req_chk(4'b0010, "R8 rx0 raised");
      @(negedge clk); vec_ack = 4'b0010; rx_evt = 8'h08;
      @(negedge clk); vec_ack = '0; rx_evt = '0;
      req_chk(4'b0000, "R8 cleared at ack");
      idle(30);
      req_chk(4'b0010, "R8 rx3 from ack cycle kept");
      ack('1); idle(30);
      req_chk(4'b0000, "R8 nothing left after ack");

      // R4 empty list
      wr(a_head(2), 32'h7FF);
      pulse(8'h04, 8'h00);
      idle(30);
      req_chk(4'b0000, "R4 empty head");
      rd_chk(a_head(2), 32'h7FF, "R4 head reads end");
      wr(a_head(2), 32'h002);
      idle(30);
      req_chk(4'b1000, "R9 rx2 latched across empty list");
      ack('1); idle(3);

      // R6 vector field mismatch
      wr(a_rx(4), mk_ctl(1, 0, 1'b1, 0, 1'b1, 4));
      pulse(8'h10, 8'h00);
      idle(30);
      req_chk(4'b0000, "R6 mismatched vector field");
      wr(a_rx(4), mk_ctl(2, 0, 1'b1, 0, 1'b1, 4));
      idle(30);
      req_chk(4'b0100, "R6 matching vector field");
      ack('1); idle(3);

      // R10 looping list
      wr(a_tx(0), mk_ctl(1, 0, 1'b1, 1, 1'b0, 0));
      pulse(8'h01, 8'h00);
      idle(50);
      check(loop_err == 4'b0010, "R10 loop flagged", 32'(loop_err), 32'h2);
      req_chk(4'b0010, "R10 hit before loop bound");
      wr(a_tx(0), mk_ctl(1, 0, 1'b1, 1, 1'b0, 3));
      wr(a_head(0), 32'h000);
      check(loop_err == 4'b0000, "R10 cleared by head write", 32'(loop_err), 0);
      idle(50);
      check(loop_err == 4'b0000, "R10 stays clear", 32'(loop_err), 0);
      ack('1); idle(3);

      // R11 R12 shared mode
      wr(8'h00, 32'h1);
      wr(8'h01, 32'h000);
      wr(a_rx(0), mk_ctl(0, 0, 1'b1, 0, 1'b1, 0));
      wr(a_tx(0), mk_ctl(0, 1, 1'b1, 1, 1'b0, 11'h7FF));
      pulse(8'h02, 8'h01);
      idle(30);
      req_chk(4'b0001, "R11 shared raises only vector 0");
      rd_chk(8'h02, 32'h2, "R11 cause bit from select 1");
      ack(4'b0001); idle(2);
      rd_chk(8'h02, 32'h0, "R12 cause cleared by ack");
      req_chk(4'b0000, "R12 vector 0 acked");
      wr(a_rx(0), mk_ctl(0, 7, 1'b1, 0, 1'b1, 0));
      pulse(8'h01, 8'h00);
      idle(30);
      req_chk(4'b0001, "R11 select 7 still requests");
      rd_chk(8'h02, 32'h0, "R11 select 7 sets no cause bit");
      ack(4'b0001); idle(3);
      wr(8'h00, 32'h0);
      idle(30);
      req_chk(4'b0100, "R11 rx1 held until vectored mode");
      ack('1); idle(3);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule